// File: doc/BRIEF.md
# Indexed Block-Access Configuration Register Target

This block is a serial two-wire bus target that serves a bank of eight byte-wide configuration registers. The system clock oversamples the clock and data lines. Both lines pass through a two-stage synchronizer and a glitch filter. The block then finds the start and stop conditions and decodes each byte on the clock edges. It pulls the data line low through an open-drain enable, for its own acknowledge bits and for the zero bits of the bytes it returns.

Every transaction names a starting register index. A host writes by sending its address with the write bit, an index, a transfer length and then the data bytes. A host reads by sending its address with the write bit and an index, then a repeated start and its address with the read bit. The target answers a read with the value of its length register first and then streams register contents from the index onward. The index steps after every data byte and wraps within the eight locations.

The target address is one of three adjacent values chosen by a strap code, which is captured once after reset. The four writable configuration bytes drive a parallel output for the rest of the chip. An input that reports whether the reference clock is running gates the whole interface.

Top module: `idxblk_target`

## Requirements
- R1: The strap code is captured on the first clock after reset and held until the next reset: code 00 selects address 0x6B, code 01 selects 0x6C, and codes 10 and 11 select 0x6D. Only the captured address is acknowledged, and later changes of the strap pins have no effect.
- R2: A write frame carries its address with R/W=0, then an index byte, then a length byte, then data bytes. The target acknowledges every byte and stores the data bytes at consecutive indices, starting from the low three bits of the index byte. The length byte is acknowledged and otherwise ignored.
- R3: After a write-addressed index byte, a repeated start and the address with R/W=1 start a read. The first byte returned is the length register, with bits 7:5 reading zero. The following bytes are the registers from the index onward, MSB first.
- R4: The reset values by index are 0:0xFF, 1:0x6E, 2:0xFF, 3:0xC7, 4:0x00, 5:0x01, 6:0x85 and 7:0x08.
- R5: Writes to index 4 (reserved), 5 (revision/vendor) and 6 (type/device) are acknowledged and change nothing. A write to index 7 keeps only bits 4:0.
- R6: The index advances by one after each data byte written or sent, and wraps from 7 to 0.
- R7: A host NACK after a returned byte ends the read: the target releases the data line and sends nothing more.
- R8: A stop condition, wherever it falls, returns the target to idle and discards any partial byte. A start condition, wherever it falls, begins a new address phase.
- R9: While the reference-running input is low the target acknowledges nothing and never drives the data line.
- R10: A pulse shorter than three system clocks on either line is ignored. It neither shifts a bit nor forms a start or stop.
- R11: The parallel configuration output carries registers 0 to 3, with index 0 in bits 7:0. It changes only when a data byte is written to one of those registers.
- R12: The data-line pull-down turns on only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| refActive | input | 1 | High while the reference clock is running. Low silences the interface |
| strapCode | input | 2 | Address strap code: 00 low, 01 mid, 1x high |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When high, the pad pulls the data line low |
| cfgBytes | output | 32 | Registers 0 to 3; index 0 in bits 7:0 |

## Verification
The checker watches several rules on every cycle. The strap address must stay fixed once captured. Any stop must leave the controller idle on the next cycle. A low reference-running input must silence the data line. Each register write must step the index by exactly one. The configuration output must hold whenever no write strobe fires. The pull-down may rise only while the clock line is low.

Other behaviours only show at the bus, so the bench's scenarios cover them. These are the address decode for every strap code, the wrapped index order, and the length byte leading a read. The bench also covers the read-only and reserved locations, abandoned partial bytes, NACK termination and glitch rejection. It compares each byte read back against a model of the register file.

// File: rtl/idxblk_pkg.sv
package idxblk_pkg;
  localparam int IDX_W    = 3;
  localparam int REG_N    = 1 << IDX_W;
  localparam int CFG_N    = 4;
  localparam int CFG_AW   = $clog2(CFG_N);
  localparam int BC_W     = 5;
  localparam int RSV_IDX  = 4;
  localparam int VEND_IDX = 5;
  localparam int DEV_IDX  = 6;
  localparam int CNT_IDX  = REG_N - 1;

  typedef struct packed {
    logic shiftRx;
    logic setIdx;
    logic writeReg;
    logic loadCnt;
    logic loadData;
    logic shiftTx;
  } strobe_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_HACK} state_t;
  typedef enum logic [1:0] {K_ADDR, K_IDX, K_CNT, K_DATA} kind_t;
endpackage

// File: rtl/idxblk_deglitch.sv
module idxblk_deglitch #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic syncA, syncB;
  logic [CW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= 1'b1;
      syncB  <= 1'b1;
      level  <= 1'b1;
      runLen <= '0;
    end else begin
      syncA <= raw;
      syncB <= syncA;
      if (syncB != level) begin
        if (runLen == CW'(FILT_LEN - 1)) begin
          level  <= syncB;
          runLen <= '0;
        end else begin
          runLen <= runLen + 1'b1;
        end
      end else begin
        runLen <= '0;
      end
    end
  end
endmodule

// File: rtl/idxblk_datapath.sv
module idxblk_datapath
  import idxblk_pkg::*;
#(
  parameter int                  FILT_LEN    = 3,
  parameter logic [6:0]          ADDR_BASE   = 7'h6B,
  parameter logic [CFG_N*8-1:0]  CFG_RST     = 32'hC7FF6EFF,
  parameter logic [7:0]          VENDOR_BYTE = 8'h01,
  parameter logic [7:0]          DEVICE_BYTE = 8'h85,
  parameter logic [BC_W-1:0]     BC_RST      = 5'd8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRaw,
  input  logic               sdaRaw,
  input  logic [1:0]         strapCode,
  input  strobe_t            strb,
  output logic               sclRise,
  output logic               sclFall,
  output logic               startSeen,
  output logic               stopSeen,
  output logic               sdaLvl,
  output logic               addrHit,
  output logic               rwBit,
  output logic               txMsb,
  output logic [IDX_W-1:0]   idx,
  output logic [6:0]         devAddr,
  output logic [CFG_N*8-1:0] cfgBytes
);
  logic [1:0] rawBus, lvl;
  logic       sclPrev, sdaPrev;
  logic       strapLocked;
  logic [7:0] rxShift, txShift, readByte;
  logic [CFG_N-1:0][7:0] cfgReg;
  logic [BC_W-1:0] bcReg;

  assign rawBus = {sdaRaw, sclRaw};

  for (genvar g = 0; g < 2; g++) begin : g_line
    idxblk_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk(clk), .rstN(rstN), .raw(rawBus[g]), .level(lvl[g])
    );
  end

  assign sdaLvl    = lvl[1];
  assign sclRise   = lvl[0] & ~sclPrev;
  assign sclFall   = ~lvl[0] & sclPrev;
  assign startSeen = lvl[0] & sclPrev & sdaPrev & ~lvl[1];
  assign stopSeen  = lvl[0] & sclPrev & ~sdaPrev & lvl[1];
  assign addrHit   = (rxShift[7:1] == devAddr);
  assign rwBit     = rxShift[0];
  assign txMsb     = txShift[7];
  assign cfgBytes  = cfgReg;

  always_comb begin
    readByte = 8'h00;
    if (idx < IDX_W'(CFG_N))            readByte = cfgReg[idx[CFG_AW-1:0]];
    else if (idx == IDX_W'(VEND_IDX))   readByte = VENDOR_BYTE;
    else if (idx == IDX_W'(DEV_IDX))    readByte = DEVICE_BYTE;
    else if (idx == IDX_W'(CNT_IDX))    readByte = {{(8-BC_W){1'b0}}, bcReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev     <= 1'b1;
      sdaPrev     <= 1'b1;
      strapLocked <= 1'b0;
      devAddr     <= ADDR_BASE;
      rxShift     <= '0;
      txShift     <= '1;
      idx         <= '0;
      cfgReg      <= CFG_RST;
      bcReg       <= BC_RST;
    end else begin
      sclPrev <= lvl[0];
      sdaPrev <= lvl[1];
      if (!strapLocked) begin
        strapLocked <= 1'b1;
        devAddr     <= ADDR_BASE + 7'(strapCode[1] ? 2'd2 : {1'b0, strapCode[0]});
      end
      if (strb.shiftRx) rxShift <= {rxShift[6:0], lvl[1]};
      if (strb.loadCnt)       txShift <= {{(8-BC_W){1'b0}}, bcReg};
      else if (strb.loadData) txShift <= readByte;
      else if (strb.shiftTx)  txShift <= {txShift[6:0], 1'b1};
      if (strb.writeReg) begin
        if (idx < IDX_W'(CFG_N))          cfgReg[idx[CFG_AW-1:0]] <= rxShift;
        else if (idx == IDX_W'(CNT_IDX))  bcReg <= rxShift[BC_W-1:0];
      end
      if (strb.setIdx)                         idx <= rxShift[IDX_W-1:0];
      else if (strb.writeReg || strb.loadData) idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/idxblk_control.sv
module idxblk_control
  import idxblk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    refActive,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startSeen,
  input  logic    stopSeen,
  input  logic    sdaLvl,
  input  logic    addrHit,
  input  logic    rwBit,
  input  logic    txMsb,
  output strobe_t strb,
  output logic    sdaOe,
  output logic    ctlIdle
);
  state_t     state, stN;
  kind_t      kind, kN;
  logic [3:0] bitCnt, bN;
  logic       readMode, rmN, hostAck, haN;

  always_comb begin
    stN  = state;
    kN   = kind;
    bN   = bitCnt;
    rmN  = readMode;
    haN  = hostAck;
    strb = '0;
    if (!refActive || stopSeen) begin
      stN = ST_IDLE;
      bN  = '0;
    end else if (startSeen) begin
      stN = ST_RX;
      kN  = K_ADDR;
      bN  = '0;
      rmN = 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && bitCnt != 4'd8) begin
            strb.shiftRx = 1'b1;
            bN = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bN  = '0;
            stN = ST_ACK;
            case (kind)
              K_ADDR:  if (!addrHit) stN = ST_IDLE; else rmN = rwBit;
              K_IDX:   strb.setIdx = 1'b1;
              K_DATA:  strb.writeReg = 1'b1;
              default: ;
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            if (readMode) begin
              strb.loadCnt = 1'b1;
              stN = ST_TX;
              bN  = '0;
            end else begin
              stN = ST_RX;
              kN  = (kind == K_ADDR) ? K_IDX : ((kind == K_IDX) ? K_CNT : K_DATA);
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stN = ST_HACK;
              bN  = '0;
            end else begin
              strb.shiftTx = 1'b1;
              bN = bitCnt + 4'd1;
            end
          end
        end
        ST_HACK: begin
          if (sclRise) begin
            haN = ~sdaLvl;
          end else if (sclFall) begin
            if (hostAck) begin
              strb.loadData = 1'b1;
              stN = ST_TX;
            end else begin
              stN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      bitCnt   <= '0;
      readMode <= 1'b0;
      hostAck  <= 1'b0;
    end else begin
      state    <= stN;
      kind     <= kN;
      bitCnt   <= bN;
      readMode <= rmN;
      hostAck  <= haN;
    end
  end

  assign sdaOe   = (state == ST_ACK) || (state == ST_TX && !txMsb);
  assign ctlIdle = (state == ST_IDLE);
endmodule

// File: rtl/idxblk_target.sv
module idxblk_target
  import idxblk_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refActive,
  input  logic [1:0]         strapCode,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  output logic [CFG_N*8-1:0] cfgBytes
);
  strobe_t          strb;
  logic             sclRise, sclFall, startSeen, stopSeen, sdaLvl;
  logic             addrHit, rwBit, txMsb, ctlIdle;
  logic [IDX_W-1:0] idx;
  logic [6:0]       devAddr;

  idxblk_datapath #(.FILT_LEN(FILT_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn), .strapCode(strapCode),
    .strb(strb), .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .sdaLvl(sdaLvl), .addrHit(addrHit), .rwBit(rwBit),
    .txMsb(txMsb), .idx(idx), .devAddr(devAddr), .cfgBytes(cfgBytes)
  );

  idxblk_control u_ctl (
    .clk(clk), .rstN(rstN), .refActive(refActive), .sclRise(sclRise),
    .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen), .sdaLvl(sdaLvl),
    .addrHit(addrHit), .rwBit(rwBit), .txMsb(txMsb), .strb(strb),
    .sdaOe(sdaOe), .ctlIdle(ctlIdle)
  );
endmodule

// File: rtl/idxblk_checker.sv
module idxblk_checker
  import idxblk_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               refActive,
  input logic               sclIn,
  input logic               sdaOe,
  input logic               stopSeen,
  input logic               ctlIdle,
  input strobe_t            strb,
  input logic [IDX_W-1:0]   idx,
  input logic [6:0]         devAddr,
  input logic [CFG_N*8-1:0] cfgBytes
);
  logic seenOne;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenOne <= 1'b0;
    else       seenOne <= 1'b1;
  end

  a_r1_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    seenOne |=> $stable(devAddr));

  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> ctlIdle);

  a_r9_silent: assert property (@(posedge clk) disable iff (!rstN)
    !refActive |=> (!sdaOe && ctlIdle));

  a_r6_index_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeReg |=> (idx == IDX_W'($past(idx) + 1'b1)));

  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeReg |=> $stable(cfgBytes));

  a_r12_pull_clk_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);
endmodule

bind idxblk_target idxblk_checker u_chk (
  .clk(clk), .rstN(rstN), .refActive(refActive), .sclIn(sclIn), .sdaOe(sdaOe),
  .stopSeen(stopSeen), .ctlIdle(ctlIdle), .strb(strb), .idx(idx),
  .devAddr(devAddr), .cfgBytes(cfgBytes)
);

// File: tb/idxblk_target_tb.sv
module idxblk_target_tb;
  localparam int Q = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        refActive = 1'b1;
  logic [1:0]  strapCode = 2'b00;
  logic        sclH = 1'b1;
  logic        sdaH = 1'b1;
  logic        sdaOe;
  logic [31:0] cfgBytes;
  wire         sdaBus = sdaH & ~sdaOe;

  idxblk_target u_dut (
    .clk(clk), .rstN(rstN), .refActive(refActive), .strapCode(strapCode),
    .sclIn(sclH), .sdaIn(sdaBus), .sdaOe(sdaOe), .cfgBytes(cfgBytes)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] model [8];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic [7:0] rcnt;
  logic glitchOn = 1'b0;
  logic [6:0] myAddr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] addrFor(input logic [1:0] code);
    return code[1] ? 7'h6D : (code[0] ? 7'h6C : 7'h6B);
  endfunction

  task automatic modelReset();
    model[0] = 8'hFF; model[1] = 8'h6E; model[2] = 8'hFF; model[3] = 8'hC7;
    model[4] = 8'h00; model[5] = 8'h01; model[6] = 8'h85; model[7] = 8'h08;
  endtask

  task automatic modelWrite(input int start, input int n);
    for (int k = 0; k < n; k++) begin
      int i = (start + k) % 8;
      if (i < 4) model[i] = wbuf[k];
      else if (i == 7) model[7] = {3'b000, wbuf[k][4:0]};
    end
  endtask

  task automatic doReset(input logic [1:0] code);
    rstN = 1'b0; strapCode = code; sclH = 1'b1; sdaH = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    modelReset();
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic hStart();
    sdaH = 1'b1; qwait(); sclH = 1'b1; qwait(); sdaH = 1'b0; qwait(); sclH = 1'b0; qwait();
  endtask

  task automatic hStop();
    sdaH = 1'b0; qwait(); sclH = 1'b1; qwait(); sdaH = 1'b1; qwait();
  endtask

  task automatic hBit(input logic b, output logic s);
    sdaH = b; qwait(); sclH = 1'b1;
    if (glitchOn) begin
      repeat (4) @(negedge clk); sclH = 1'b0;
      repeat (2) @(negedge clk); sclH = 1'b1;
      repeat (4) @(negedge clk); sdaH = ~b;
      repeat (2) @(negedge clk); sdaH = b;
      repeat (Q - 12) @(negedge clk);
    end else begin
      qwait();
    end
    s = sdaBus; qwait(); sclH = 1'b0; qwait();
  endtask

  task automatic hSendByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) hBit(v[i], s);
    hBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic hRecvByte(input logic giveAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin hBit(1'b1, s); v[i] = s; end
    hBit(~giveAck, s);
  endtask

  task automatic probe(input logic [6:0] a, output logic ack);
    hStart(); hSendByte({a, 1'b0}, ack); hStop();
  endtask

  task automatic doWrite(input logic [6:0] a, input logic [7:0] idx, input int n, output logic ok);
    logic k;
    hStart();
    hSendByte({a, 1'b0}, k); ok = k;
    hSendByte(idx, k); ok &= k;
    hSendByte(8'(n), k); ok &= k;
    for (int i = 0; i < n; i++) begin hSendByte(wbuf[i], k); ok &= k; end
    hStop();
  endtask

  task automatic doRead(input logic [6:0] a, input logic [7:0] idx, input int n, output logic ok);
    logic k;
    hStart();
    hSendByte({a, 1'b0}, k); ok = k;
    hSendByte(idx, k); ok &= k;
    hStart();
    hSendByte({a, 1'b1}, k); ok &= k;
    hRecvByte(1'b1, rcnt);
    for (int i = 0; i < n; i++) hRecvByte(i != n - 1, rbuf[i]);
    chk("R7 released after NACK", 32'(sdaOe), 32'd0);
    hStop();
  endtask

  task automatic readCompare(input string req, input int idx, input int n);
    logic ok;
    doRead(myAddr, 8'(idx), n, ok);
    chk({req, " read acks"}, 32'(ok), 32'd1);
    chk({req, " R3 count byte"}, 32'(rcnt), 32'(model[7]));
    for (int i = 0; i < n; i++)
      chk({req, " data"}, 32'(rbuf[i]), 32'(model[(idx + i) % 8]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack, ok;
    int seedVal;
    seedVal = $urandom(32'd20240611);

    // R1: every strap code, captured address acked, neighbours not
    for (int code = 0; code < 4; code++) begin
      doReset(2'(code));
      for (int a = 'h6A; a <= 'h6E; a++) begin
        probe(7'(a), ack);
        chk("R1 address decode", 32'(ack), 32'(7'(a) == addrFor(2'(code))));
      end
    end
    doReset(2'b00);
    strapCode = 2'b10;
    probe(7'h6B, ack);
    chk("R1 strap held after change", 32'(ack), 32'd1);
    probe(7'h6D, ack);
    chk("R1 new strap ignored", 32'(ack), 32'd0);

    // R4 / R11: reset state
    doReset(2'b01);
    myAddr = 7'h6C;
    chk("R4 sdaOe at reset", 32'(sdaOe), 32'd0);
    chk("R11 cfg reset", cfgBytes, 32'hC7FF6EFF);
    readCompare("R4 defaults", 0, 8);

    // R2 / R6: write across the wrap point
    wbuf[0] = 8'h11; wbuf[1] = 8'h13; wbuf[2] = 8'hA7; wbuf[3] = 8'h3C;
    doWrite(myAddr, 8'd6, 4, ok);
    chk("R2 write acks", 32'(ok), 32'd1);
    modelWrite(6, 4);
    chk("R11 cfg after write", cfgBytes, {model[3], model[2], model[1], model[0]});
    readCompare("R6 wrap", 5, 5);

    // R5: read-only and reserved locations, index 7 masking
    wbuf[0] = 8'h5A; wbuf[1] = 8'hF0; wbuf[2] = 8'h0F; wbuf[3] = 8'hFF;
    doWrite(myAddr, 8'd4, 4, ok);
    chk("R5 acks on protected", 32'(ok), 32'd1);
    modelWrite(4, 4);
    readCompare("R5 protected", 4, 4);
    chk("R5 count masked", 32'(rcnt), 32'h1F);

    // R2: index byte upper bits dropped
    wbuf[0] = 8'h42;
    doWrite(myAddr, 8'hFA, 1, ok);
    modelWrite(2, 1);
    readCompare("R2 index low bits", 2, 1);

    // R8: stop in the middle of a data byte
    begin
      logic s;
      hStart();
      hSendByte({myAddr, 1'b0}, ack);
      hSendByte(8'd1, ack);
      hSendByte(8'd1, ack);
      hBit(1'b1, s); hBit(1'b0, s); hBit(1'b1, s); hBit(1'b0, s);
      hStop();
    end
    readCompare("R8 partial discarded", 1, 1);

    // R8: start in the middle of an index byte restarts address phase
    begin
      logic s;
      hStart();
      hSendByte({myAddr, 1'b0}, ack);
      hBit(1'b0, s); hBit(1'b1, s); hBit(1'b1, s);
      hStart();
      hSendByte({myAddr, 1'b0}, ack);
      chk("R8 restart acks address", 32'(ack), 32'd1);
      hSendByte(8'd3, ack);
      hSendByte(8'd1, ack);
      hSendByte(8'h9E, ack);
      hStop();
      wbuf[0] = 8'h9E;
      modelWrite(3, 1);
    end
    readCompare("R8 restart write", 3, 1);

    // R9: interface silent without reference clock
    refActive = 1'b0;
    wbuf[0] = 8'h00;
    doWrite(myAddr, 8'd0, 1, ok);
    chk("R9 no ack", 32'(ok), 32'd0);
    refActive = 1'b1;
    repeat (4) @(negedge clk);
    readCompare("R9 unchanged", 0, 1);

    // R10: glitches on both lines during a write
    wbuf[0] = 8'hB6; wbuf[1] = 8'h2D;
    glitchOn = 1'b1;
    doWrite(myAddr, 8'd1, 2, ok);
    glitchOn = 1'b0;
    chk("R10 acks under glitches", 32'(ok), 32'd1);
    modelWrite(1, 2);
    readCompare("R10 data under glitches", 1, 2);

    // Random traffic: R2, R3, R6
    for (int it = 0; it < 8; it++) begin
      int wi, wn, ri, rn;
      wi = int'($urandom % 8); wn = 1 + int'($urandom % 4);
      for (int k = 0; k < wn; k++) wbuf[k] = 8'($urandom);
      doWrite(myAddr, 8'(wi), wn, ok);
      chk("R2 random write acks", 32'(ok), 32'd1);
      modelWrite(wi, wn);
      ri = int'($urandom % 8); rn = 1 + int'($urandom % 4);
      readCompare("R6 random", ri, rn);
      chk("R11 cfg random", cfgBytes, {model[3], model[2], model[1], model[0]});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule